// File: doc/BRIEF.md
# Longest Carry-Chain Weight Classifier

This block watches the operand pairs that enter an adder and measures how far a carry can travel for each pair. For every pair accepted with a valid strobe, it locates each carry chain and takes the length of the longest one as the pair's weight. The weight and its bin are presented on registered outputs one cycle later. The weight also advances one of a small bank of histogram counters, so the spread of carry-chain lengths across a workload can be gathered in silicon.

The block does not add the operands; it only classifies them. Software or a test controller reads the histogram one bin at a time through an index and read-data port, and can zero every bin at once with a clear strobe. Bins split the range 1..WIDTH into NUM_BINS equal spans, and weight 0 falls into the lowest bin. With the defaults of WIDTH 32 and NUM_BINS 4, the bins cover weights 0-8, 9-16, 17-24 and 25-32.

Top module: `chain_weight_classifier`

## Requirements
- R1: A carry chain starts at a bit i where in_a[i] and in_b[i] are both 1 (generate). It extends through each higher bit where in_a and in_b differ (propagate). Its length counts the bits from the start bit up to its last propagate bit, both inclusive. A generate bit always starts a new chain. The weight is the largest chain length and lies in 0..WIDTH.
- R2: A pair with no generate bit has weight 0, even when every bit propagates.
- R3: out_valid is high in exactly the cycle after a cycle with in_valid high, and out_weight then shows that pair's weight. Without in_valid, out_weight and out_bin hold their values.
- R4: out_bin is 0 for weights 0..8, 1 for 9..16, 2 for 17..24 and 3 for 25..32 (in general: 0 for weight 0, otherwise (weight-1)/(WIDTH/NUM_BINS)). It is registered alongside out_weight.
- R5: Each accepted pair adds one to the counter of its bin. The new value is visible on rd_count once the clock edge that sampled in_valid has passed.
- R6: rd_count shows the counter selected by rd_idx without a clock edge. Reading never changes any counter.
- R7: A counter at 2^CNT_W-1 stays there when more pairs fall into its bin. It never wraps.
- R8: A cycle with clr high zeroes every counter at the next edge. If clr and in_valid are both high, clr wins: counters are zero afterwards, while the weight output still reports the pair.
- R9: While reset is applied, and after it, out_valid and out_weight are 0 and every counter reads 0 until new pairs arrive.
- R10: A pair holding several separate chains reports the length of the longest one, not their sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair on in_a/in_b is accepted this cycle |
| in_a | input | WIDTH | First adder operand |
| in_b | input | WIDTH | Second adder operand |
| clr | input | 1 | Zero all histogram counters |
| rd_idx | input | clog2(NUM_BINS) | Histogram bin selected for reading |
| out_weight | output | clog2(WIDTH+1) | Longest carry-chain length of the last accepted pair |
| out_bin | output | clog2(NUM_BINS) | Bin of the last accepted pair |
| out_valid | output | 1 | out_weight/out_bin refreshed this cycle |
| rd_count | output | CNT_W | Count held in bin rd_idx |

## Verification
The assertions check on every cycle that the output strobe follows the input strobe by one cycle and that the weight holds between pairs. They also check that pairs with or without a generate bit give a nonzero or zero weight, that the bin agrees with the registered weight, and that a clear empties the read bin. A counter may only fall after a clear, which catches wrapping. The exact chain length depends on the data: that a generate bit restarts a chain, that separate chains are not summed, and the bin boundaries at 8/9, 16/17 and 24/25 can only be shown by the bench's chosen operand pairs. The same holds for the saturation value, and for clear winning over a concurrent pair.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  localparam int unsigned CWC_DEF_WIDTH = 32;
  localparam int unsigned CWC_DEF_BINS  = 4;
  localparam int unsigned CWC_DEF_CNT_W = 16;

  function automatic int unsigned cwc_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cwc_chain_scan.sv
module cwc_chain_scan #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned WW    = 6
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WW-1:0]    longest
);
  logic [WIDTH-1:0] gen_bit;
  logic [WIDTH-1:0] prop_bit;
  logic [WW-1:0]    run_len [WIDTH];

  assign gen_bit  = op_a & op_b;
  assign prop_bit = op_a ^ op_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_run
    if (i == 0) begin : g_lsb
      assign run_len[i] = gen_bit[i] ? WW'(1) : '0;
    end else begin : g_upper
      always_comb begin
        if (gen_bit[i]) begin
          run_len[i] = WW'(1);
        end else if (prop_bit[i] && (run_len[i-1] != '0)) begin
          run_len[i] = run_len[i-1] + WW'(1);
        end else begin
          run_len[i] = '0;
        end
      end
    end
  end

  always_comb begin
    longest = '0;
    for (int k = 0; k < WIDTH; k++) begin
      if (run_len[k] > longest) begin
        longest = run_len[k];
      end
    end
  end
endmodule

// File: rtl/cwc_bin_map.sv
module cwc_bin_map #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned NUM_BINS = 4,
  parameter int unsigned WW       = 6,
  parameter int unsigned BI_W     = 2
) (
  input  logic [WW-1:0]   weight,
  output logic [BI_W-1:0] bin
);
  localparam int unsigned SPAN = (WIDTH / NUM_BINS > 0) ? WIDTH / NUM_BINS : 1;

  logic [WW-1:0] w_minus_one;
  logic [WW-1:0] raw_bin;

  assign w_minus_one = weight - WW'(1);
  assign raw_bin     = w_minus_one / WW'(SPAN);

  always_comb begin
    if (weight == '0) begin
      bin = '0;
    end else if (int'(raw_bin) >= NUM_BINS) begin
      bin = BI_W'(NUM_BINS - 1);
    end else begin
      bin = BI_W'(raw_bin);
    end
  end
endmodule

// File: rtl/cwc_hist_bank.sv
module cwc_hist_bank #(
  parameter int unsigned NUM_BINS = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned BI_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            inc_en,
  input  logic [BI_W-1:0] inc_bin,
  input  logic [BI_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM_BINS];
  logic [CNT_W-1:0] cnt_d [NUM_BINS];
  logic [NUM_BINS-1:0] cnt_en;

  for (genvar k = 0; k < NUM_BINS; k++) begin : g_bin
    always_comb begin
      cnt_en[k] = 1'b0;
      cnt_d[k]  = cnt_q[k];
      if (clr) begin
        cnt_en[k] = 1'b1;
        cnt_d[k]  = '0;
      end else if (inc_en && (inc_bin == BI_W'(k)) && (cnt_q[k] != CNT_MAX)) begin
        cnt_en[k] = 1'b1;
        cnt_d[k]  = cnt_q[k] + CNT_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[k] <= '0;
      end else if (cnt_en[k]) begin
        cnt_q[k] <= cnt_d[k];
      end
    end
  end

  always_comb begin
    rd_count = '0;
    for (int k = 0; k < NUM_BINS; k++) begin
      if (rd_idx == BI_W'(k)) begin
        rd_count = cnt_q[k];
      end
    end
  end
endmodule

// File: rtl/chain_weight_classifier.sv
module chain_weight_classifier
  import cwc_pkg::*;
#(
  parameter int unsigned WIDTH    = CWC_DEF_WIDTH,
  parameter int unsigned NUM_BINS = CWC_DEF_BINS,
  parameter int unsigned CNT_W    = CWC_DEF_CNT_W,
  localparam int unsigned WW      = $clog2(WIDTH + 1),
  localparam int unsigned BI_W    = cwc_idx_w(NUM_BINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             clr,
  input  logic [BI_W-1:0]  rd_idx,
  output logic [WW-1:0]    out_weight,
  output logic [BI_W-1:0]  out_bin,
  output logic             out_valid,
  output logic [CNT_W-1:0] rd_count
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [WW-1:0]   scan_weight;
  logic [BI_W-1:0] scan_bin;
  logic [WW-1:0]   weight_d;
  logic [BI_W-1:0] bin_d;
  logic            valid_d;
  logic            res_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  cwc_chain_scan #(
    .WIDTH (WIDTH),
    .WW    (WW)
  ) u_scan (
    .op_a    (in_a),
    .op_b    (in_b),
    .longest (scan_weight)
  );

  cwc_bin_map #(
    .WIDTH    (WIDTH),
    .NUM_BINS (NUM_BINS),
    .WW       (WW),
    .BI_W     (BI_W)
  ) u_map (
    .weight (scan_weight),
    .bin    (scan_bin)
  );

  always_comb begin
    res_en   = in_valid;
    weight_d = out_weight;
    bin_d    = out_bin;
    valid_d  = 1'b0;
    if (in_valid) begin
      weight_d = scan_weight;
      bin_d    = scan_bin;
      valid_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_weight <= '0;
      out_bin    <= '0;
    end else if (res_en) begin
      out_weight <= weight_d;
      out_bin    <= bin_d;
    end
  end

  cwc_hist_bank #(
    .NUM_BINS (NUM_BINS),
    .CNT_W    (CNT_W),
    .BI_W     (BI_W)
  ) u_hist (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .inc_en   (in_valid),
    .inc_bin  (scan_bin),
    .rd_idx   (rd_idx),
    .rd_count (rd_count)
  );
endmodule

// File: rtl/cwc_checker.sv
module cwc_checker #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned NUM_BINS = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned WW       = 6,
  parameter int unsigned BI_W     = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             clr,
  input logic [BI_W-1:0]  rd_idx,
  input logic [WW-1:0]    out_weight,
  input logic [BI_W-1:0]  out_bin,
  input logic             out_valid,
  input logic [CNT_W-1:0] rd_count
);
  localparam int unsigned SPAN = (WIDTH / NUM_BINS > 0) ? WIDTH / NUM_BINS : 1;

  function automatic int unsigned exp_bin(input int unsigned w);
    int unsigned b;
    if (w == 0) return 0;
    b = (w - 1) / SPAN;
    return (b >= NUM_BINS) ? NUM_BINS - 1 : b;
  endfunction

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R3
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid); // R3
  AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ($stable(out_weight) && $stable(out_bin))); // R3
  AST_WEIGHT_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (int'(out_weight) <= WIDTH)); // R1
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && ((in_a & in_b) != '0)) |=> (out_weight != '0)); // R1
  AST_NO_GEN_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && ((in_a & in_b) == '0)) |=> (out_weight == '0)); // R2
  AST_BIN_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (int'(out_bin) == exp_bin(int'(out_weight)))); // R4
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(clr) |-> (rd_count == '0)); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($stable(rd_idx) && !$past(clr)) |-> (rd_count >= $past(rd_count))); // R7
endmodule

bind chain_weight_classifier cwc_checker #(
  .WIDTH    (WIDTH),
  .NUM_BINS (NUM_BINS),
  .CNT_W    (CNT_W),
  .WW       (WW),
  .BI_W     (BI_W)
) u_cwc_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_a       (in_a),
  .in_b       (in_b),
  .clr        (clr),
  .rd_idx     (rd_idx),
  .out_weight (out_weight),
  .out_bin    (out_bin),
  .out_valid  (out_valid),
  .rd_count   (rd_count)
);

// File: tb/chain_weight_classifier_bench.sv
`timescale 1ns/1ps
module chain_weight_classifier_bench;
  localparam int W     = 32;
  localparam int NB    = 4;
  localparam int CW    = 4;
  localparam int CMAX  = 15;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  in_a;
  logic [W-1:0]  in_b;
  logic          clr;
  logic [1:0]    rd_idx;
  logic [5:0]    out_weight;
  logic [1:0]    out_bin;
  logic          out_valid;
  logic [CW-1:0] rd_count;

  int n_tests;
  int n_fail;
  int model_cnt [NB];
  bit done;

  chain_weight_classifier #(
    .WIDTH    (W),
    .NUM_BINS (NB),
    .CNT_W    (CW)
  ) u_chain_weight_classifier (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_a       (in_a),
    .in_b       (in_b),
    .clr        (clr),
    .rd_idx     (rd_idx),
    .out_weight (out_weight),
    .out_bin    (out_bin),
    .out_valid  (out_valid),
    .rd_count   (rd_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int ref_weight(input logic [W-1:0] a, input logic [W-1:0] b);
    int best = 0;
    for (int i = 0; i < W; i++) begin
      if (a[i] && b[i]) begin
        int len = 1;
        int j = i + 1;
        while (j < W && (a[j] != b[j])) begin
          len++;
          j++;
        end
        if (len > best) best = len;
      end
    end
    return best;
  endfunction

  function automatic int ref_bin(input int w);
    if (w <= 8)  return 0;
    if (w <= 16) return 1;
    if (w <= 24) return 2;
    return 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_bin(input int idx, input int exp, input string req);
    @(negedge clk);
    rd_idx = 2'(idx);
    #1;
    check(int'(rd_count) == exp, req, int'(rd_count), exp);
  endtask

  task automatic send_check(input logic [W-1:0] a, input logic [W-1:0] b,
                            input int exp_w, input string req);
    int w;
    int bn;
    w  = ref_weight(a, b);
    bn = ref_bin(w);
    check(w == exp_w, {req, " bench reference"}, w, exp_w);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R3 out_valid", int'(out_valid), 1);
    check(int'(out_weight) == w, req, int'(out_weight), w);
    check(int'(out_bin) == bn, "R4 bin", int'(out_bin), bn);
    if (model_cnt[bn] < CMAX) model_cnt[bn]++;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    check(out_weight == '0, "R9 out_weight", int'(out_weight), 0);
    for (int k = 0; k < NB; k++) read_bin(k, 0, "R9 counter");
  endtask

  task automatic t_patterns();
    send_check(32'h0, 32'h0, 0, "R2 all zero");
    send_check(32'hFFFF_FFFF, 32'h0, 0, "R2 all propagate");
    send_check(32'h1, 32'h1, 1, "R1 single generate");
    send_check(32'h3, 32'h3, 1, "R1 generate restarts chain");
    send_check(32'h0000_000F, 32'h0000_00F1, 8, "R1 R4 weight 8");
    send_check(32'h1, 32'h0000_01FF, 9, "R1 R4 weight 9");
    send_check(32'h1, 32'h0000_FFFF, 16, "R4 weight 16");
    send_check(32'h1, 32'h0001_FFFF, 17, "R4 weight 17");
    send_check(32'h1, 32'h00FF_FFFF, 24, "R4 weight 24");
    send_check(32'h1, 32'h01FF_FFFF, 25, "R4 weight 25");
    send_check(32'h1, 32'hFFFF_FFFF, 32, "R1 full width");
    send_check(32'h0001_0001, 32'h003F_0007, 6, "R10 longest of two");
  endtask

  task automatic t_hold();
    @(negedge clk);
    check(out_valid == 1'b0, "R3 idle valid", int'(out_valid), 0);
    check(int'(out_weight) == 6, "R3 weight hold", int'(out_weight), 6);
    check(int'(out_bin) == 0, "R3 bin hold", int'(out_bin), 0);
  endtask

  task automatic t_lfsr();
    logic [W-1:0] s1 = 32'hACE1_1234;
    logic [W-1:0] s2 = 32'h1357_9BDF;
    for (int n = 0; n < 12; n++) begin
      s1 = {s1[30:0], s1[31] ^ s1[21] ^ s1[1] ^ s1[0]};
      s2 = {s2[30:0], s2[31] ^ s2[21] ^ s2[1] ^ s2[0]};
      send_check(s1, s2 | s1, ref_weight(s1, s2 | s1), "R1 mixed pattern");
    end
  endtask

  task automatic t_readback();
    for (int k = 0; k < NB; k++) read_bin(k, model_cnt[k], "R5 bin count");
    read_bin(1, model_cnt[1], "R6 read no side effect");
    read_bin(1, model_cnt[1], "R6 read repeat");
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    for (int k = 0; k < NB; k++) model_cnt[k] = 0;
    for (int k = 0; k < NB; k++) read_bin(k, 0, "R8 cleared");
    @(negedge clk);
    clr = 1'b1;
    in_valid = 1'b1;
    in_a = 32'h1;
    in_b = 32'hFFFF_FFFF;
    @(negedge clk);
    clr = 1'b0;
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R8 pair still reported", int'(out_valid), 1);
    check(int'(out_weight) == 32, "R8 weight with clear", int'(out_weight), 32);
    read_bin(3, 0, "R8 clear wins");
  endtask

  task automatic t_saturate();
    for (int n = 0; n < 20; n++) send_check(32'h1, 32'hFFFF_FFFF, 32, "R7 fill");
    read_bin(3, CMAX, "R7 saturated");
    read_bin(0, 0, "R7 other bin untouched");
  endtask

  initial begin
    n_tests = 0;
    n_fail = 0;
    done = 1'b0;
    for (int k = 0; k < NB; k++) model_cnt[k] = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_a = '0;
    in_b = '0;
    clr = 1'b0;
    rd_idx = '0;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_patterns();
    t_hold();
    t_lfsr();
    t_readback();
    t_clear();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule